// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block is the gatekeeper that sits between a serial flash command decoder and the parts of the device that change stored data. When chip select rises, the decoder presents one decoded opcode, together with a flag that says whether the bit count was a whole number of bytes, the target address, and the byte that a status write would load. The controller decides whether the command is accepted or rejected, and the verdict appears one cycle later. It holds the write-enable latch, a status register with four block-protect bits and a status-write-disable bit, and the deep power-down and write-in-progress conditions. A completion strobe from the program/erase engine stub ends a write cycle.

The controller is a four-state machine. `ST_POWERUP` is entered from reset; transition *powerup_done* leads to `ST_IDLE` once the power-up wait counter expires. From `ST_IDLE`, transition *write_start* leads to `ST_WRITING` when a status write, program or erase is accepted, and transition *sleep_enter* leads to `ST_DEEP_PD` on an accepted deep power-down opcode. From `ST_WRITING`, transition *write_done* returns to `ST_IDLE` on the completion strobe. From `ST_DEEP_PD`, transition *wake* returns to `ST_IDLE` on an accepted release opcode. No other transitions exist.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset, status_o is 0x00, busy_o and deep_pd_o are 0, and no verdict is raised. Until PUW_CYCLES clock cycles have passed, only read-status (0x05) and release (0xAB) are accepted. Every other opcode, including write-enable (0x06), is rejected and changes nothing.
- R2: A command whose byte-aligned flag is low is rejected in every state. It changes no latch, no status bit and no state.
- R3: Write-enable (0x06) sets the write-enable latch. A status write (0x01), page program (0x02), sector erase (0x20), block erase (0xD8) or chip erase (0x60) is rejected while the latch is clear. Each command gives exactly one verdict, cmd_accept_o or cmd_reject_o, in the cycle after cmd_valid_i.
- R4: Write-disable (0x04) clears the latch at once. The completion of an accepted status write, program or erase also clears it.
- R5: Deep power-down (0xB9) is accepted from idle and raises deep_pd_o. While it is raised, every opcode except release (0xAB) is rejected and changes nothing. Release is accepted and lowers deep_pd_o.
- R6: The block-protect value B (status bits 5:2) locks the top 2^(B-1) 64 KB blocks of the array, or the whole array when 2^(B-1) is at least the number of blocks. B = 0 locks nothing. A program, sector erase or block erase whose address lies in a locked block is rejected.
- R7: Chip erase (0x60) is rejected whenever B is not zero.
- R8: When wp_n_i is low and status bit 7 (write-disable) is set, a status write is rejected. When either condition is absent, a status write is accepted if the latch is set.
- R9: busy_o is high from the cycle after a write is accepted until the cycle after done_i. While it is high, only read-status (0x05) is accepted.
- R10: A rejected status write, program or erase leaves the write-enable latch unchanged.
- R11: status_o is {write-disable, 0, B[3:0], latch, busy}. An accepted status write loads bit 7 and bits 5:2 from cmd_data_i, and the load takes effect when the write completes.
- R12: A command that arrives in the same cycle as done_i is judged against the busy state, so it is rejected unless it is read-status. It has no effect on the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| cmd_valid_i | input | 1 | One-cycle pulse at chip-select rise presenting a decoded command |
| cmd_op_i | input | 8 | Decoded opcode |
| cmd_aligned_i | input | 1 | High when the command bit count was a multiple of eight |
| cmd_addr_i | input | ADDR_W | Target byte address for program and erase |
| cmd_data_i | input | 8 | Byte for a status write |
| done_i | input | 1 | Completion strobe from the write engine |
| wp_n_i | input | 1 | Write-protect pin, active low |
| cmd_accept_o | output | 1 | Command accepted (one cycle after cmd_valid_i) |
| cmd_reject_o | output | 1 | Command rejected (one cycle after cmd_valid_i) |
| busy_o | output | 1 | Write in progress |
| deep_pd_o | output | 1 | Deep power-down active |
| status_o | output | 8 | Status register image |

## Verification
A new command and the completion strobe can land in the same cycle. In that cycle one function ends the write cycle and clears the latch, while the other would judge a new opcode. The bench starts a sector erase and then drives write-enable together with done_i on a single edge. It expects a reject, busy_o to fall, and the latch to stay clear, which shows that the command saw the pre-completion busy state and that the latch clear was not overridden.

// File: rtl/flash_wp_pkg.sv
`timescale 1ns/1ps
package flash_wp_pkg;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_PP   = 8'h02;
    localparam logic [7:0] OP_SE   = 8'h20;
    localparam logic [7:0] OP_BE   = 8'hD8;
    localparam logic [7:0] OP_CE   = 8'h60;
    localparam logic [7:0] OP_DP   = 8'hB9;
    localparam logic [7:0] OP_RES  = 8'hAB;

    typedef enum logic [1:0] {
        ST_POWERUP = 2'd0,
        ST_IDLE    = 2'd1,
        ST_WRITING = 2'd2,
        ST_DEEP_PD = 2'd3
    } wp_state_e;

    // Commands that alter stored data or protection state.
    function automatic logic is_modify_op(input logic [7:0] op);
        return (op == OP_WRSR) || (op == OP_PP) || (op == OP_SE) ||
               (op == OP_BE)   || (op == OP_CE);
    endfunction

endpackage

// File: rtl/wp_powerup_timer.sv
`timescale 1ns/1ps
module wp_powerup_timer #(
    parameter int PUW_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready_o
);
    localparam int CW = $clog2(PUW_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(PUW_CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt != LIMIT)
            cnt <= cnt + 1'b1;
    end

    assign ready_o = (cnt == LIMIT);

    // Once the wait has expired it stays expired until the next reset.
    assert_timer_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o);

endmodule

// File: rtl/wp_region_check.sv
`timescale 1ns/1ps
module wp_region_check #(
    parameter int ADDR_W   = 21,
    parameter int BLK_BITS = 16
) (
    input  logic [3:0]        bp_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              addr_locked_o,
    output logic              any_locked_o
);
    localparam int IDX_W = ADDR_W - BLK_BITS;
    localparam int NBLK  = 1 << IDX_W;

    logic [IDX_W-1:0] blk_idx;
    logic [IDX_W:0]   span;
    logic [IDX_W:0]   floor_idx;

    assign blk_idx = addr_i[ADDR_W-1:BLK_BITS];

    always_comb begin
        span          = '0;
        floor_idx     = '0;
        addr_locked_o = 1'b0;
        if (bp_i == 4'd0) begin
            addr_locked_o = 1'b0;
        end else if ((int'(bp_i) - 1) >= IDX_W) begin
            addr_locked_o = 1'b1;
        end else begin
            span          = (IDX_W+1)'(1) << (bp_i - 4'd1);
            floor_idx     = (IDX_W+1)'(NBLK) - span;
            addr_locked_o = ({1'b0, blk_idx} >= floor_idx);
        end
    end

    assign any_locked_o = |bp_i;

endmodule

// File: rtl/flash_wp_ctrl.sv
`timescale 1ns/1ps
module flash_wp_ctrl
    import flash_wp_pkg::*;
#(
    parameter int ADDR_W     = 21,
    parameter int BLK_BITS   = 16,
    parameter int PUW_CYCLES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic [7:0]        cmd_op_i,
    input  logic              cmd_aligned_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [7:0]        cmd_data_i,
    input  logic              done_i,
    input  logic              wp_n_i,
    output logic              cmd_accept_o,
    output logic              cmd_reject_o,
    output logic              busy_o,
    output logic              deep_pd_o,
    output logic [7:0]        status_o
);
    wp_state_e state, nxt_state;

    logic       wel, nxt_wel;
    logic [3:0] bp;
    logic       srwd;
    logic [4:0] pend_sr;
    logic       pend_is_sr;

    logic acc, rej, start_write, start_sr, commit_sr;
    logic puw_ready, addr_locked, any_locked, hw_lock;

    wp_powerup_timer #(.PUW_CYCLES(PUW_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .ready_o (puw_ready)
    );

    wp_region_check #(.ADDR_W(ADDR_W), .BLK_BITS(BLK_BITS)) u_region (
        .bp_i          (bp),
        .addr_i        (cmd_addr_i),
        .addr_locked_o (addr_locked),
        .any_locked_o  (any_locked)
    );

    assign hw_lock = srwd && !wp_n_i;

    // Next-state and verdict logic
    always_comb begin
        nxt_state   = state;
        nxt_wel     = wel;
        acc         = 1'b0;
        rej         = 1'b0;
        start_write = 1'b0;
        start_sr    = 1'b0;
        commit_sr   = 1'b0;

        if (cmd_valid_i) begin
            if (!cmd_aligned_i) begin
                rej = 1'b1;
            end else begin
                unique case (state)
                    ST_POWERUP: begin
                        if (cmd_op_i == OP_RDSR || cmd_op_i == OP_RES) acc = 1'b1;
                        else                                          rej = 1'b1;
                    end
                    ST_IDLE: begin
                        case (cmd_op_i)
                            OP_WREN: begin acc = 1'b1; nxt_wel = 1'b1; end
                            OP_WRDI: begin acc = 1'b1; nxt_wel = 1'b0; end
                            OP_RDSR, OP_RES: acc = 1'b1;
                            OP_DP: begin acc = 1'b1; nxt_state = ST_DEEP_PD; end
                            OP_WRSR: begin
                                if (wel && !hw_lock) begin
                                    acc = 1'b1; start_write = 1'b1; start_sr = 1'b1;
                                    nxt_state = ST_WRITING;
                                end else rej = 1'b1;
                            end
                            OP_PP, OP_SE, OP_BE: begin
                                if (wel && !addr_locked) begin
                                    acc = 1'b1; start_write = 1'b1;
                                    nxt_state = ST_WRITING;
                                end else rej = 1'b1;
                            end
                            OP_CE: begin
                                if (wel && !any_locked) begin
                                    acc = 1'b1; start_write = 1'b1;
                                    nxt_state = ST_WRITING;
                                end else rej = 1'b1;
                            end
                            default: rej = 1'b1;
                        endcase
                    end
                    ST_WRITING: begin
                        if (cmd_op_i == OP_RDSR) acc = 1'b1;
                        else                     rej = 1'b1;
                    end
                    ST_DEEP_PD: begin
                        if (cmd_op_i == OP_RES) begin
                            acc = 1'b1; nxt_state = ST_IDLE;
                        end else rej = 1'b1;
                    end
                endcase
            end
        end

        // powerup_done
        if (state == ST_POWERUP && puw_ready)
            nxt_state = ST_IDLE;

        // write_done: completion wins over any command in the same cycle
        if (state == ST_WRITING && done_i) begin
            nxt_state = ST_IDLE;
            nxt_wel   = 1'b0;
            commit_sr = pend_is_sr;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_POWERUP;
        else        state <= nxt_state;
    end

    // Latch, status and verdict registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel          <= 1'b0;
            bp           <= 4'd0;
            srwd         <= 1'b0;
            pend_sr      <= 5'd0;
            pend_is_sr   <= 1'b0;
            cmd_accept_o <= 1'b0;
            cmd_reject_o <= 1'b0;
        end else begin
            wel          <= nxt_wel;
            cmd_accept_o <= acc;
            cmd_reject_o <= rej;
            if (start_write) begin
                pend_is_sr <= start_sr;
                pend_sr    <= {cmd_data_i[7], cmd_data_i[5:2]};
            end
            if (commit_sr) begin
                srwd <= pend_sr[4];
                bp   <= pend_sr[3:0];
            end
        end
    end

    assign busy_o    = (state == ST_WRITING);
    assign deep_pd_o = (state == ST_DEEP_PD);
    assign status_o  = {srwd, 1'b0, bp, wel, busy_o};

    // ---------------- assertions ----------------
    assert_powerup_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POWERUP && cmd_valid_i && is_modify_op(cmd_op_i)) |=> cmd_reject_o);

    assert_unaligned_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && !cmd_aligned_i && state == ST_IDLE) |=>
            (cmd_reject_o && $stable(wel) && $stable(bp) && !busy_o && !deep_pd_o));

    assert_single_verdict_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_accept_o && cmd_reject_o));

    assert_no_latch_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cmd_valid_i && cmd_aligned_i && !wel &&
         is_modify_op(cmd_op_i)) |=> cmd_reject_o);

    assert_latch_clear_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITING && done_i) |=> (!status_o[1] && !busy_o));

    assert_deep_pd_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEEP_PD && cmd_valid_i && cmd_op_i != OP_RES) |=>
            (cmd_reject_o && deep_pd_o));

    assert_chip_erase_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cmd_valid_i && cmd_aligned_i && cmd_op_i == OP_CE &&
         bp != 4'd0) |=> cmd_reject_o);

    assert_hw_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_op_i == OP_WRSR && srwd && !wp_n_i) |=> cmd_reject_o);

    assert_busy_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cmd_valid_i && cmd_op_i != OP_RDSR) |=> cmd_reject_o);

    assert_same_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && done_i && cmd_valid_i && cmd_op_i != OP_RDSR) |=>
            (cmd_reject_o && !status_o[1]));

endmodule

// File: tb/flash_wp_ctrl_tb.sv
`timescale 1ns/1ps
module flash_wp_ctrl_tb;
    localparam int ADDR_W = 21;
    localparam int PUW    = 20;

    localparam logic [7:0] WREN = 8'h06, WRDI = 8'h04, RDSR = 8'h05, WRSR = 8'h01,
                           PP = 8'h02, SE = 8'h20, BE = 8'hD8, CE = 8'h60,
                           DP = 8'hB9, RES = 8'hAB;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [7:0]        cmd_op = 8'h00;
    logic              cmd_aligned = 1'b1;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [7:0]        cmd_data = 8'h00;
    logic              done = 1'b0;
    logic              wp_n = 1'b1;
    logic              acc, rej, busy, deep;
    logic [7:0]        status;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    flash_wp_ctrl #(.ADDR_W(ADDR_W), .BLK_BITS(16), .PUW_CYCLES(PUW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
        .cmd_aligned_i(cmd_aligned), .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data),
        .done_i(done), .wp_n_i(wp_n), .cmd_accept_o(acc), .cmd_reject_o(rej),
        .busy_o(busy), .deep_pd_o(deep), .status_o(status)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Present one command, then sample the verdict one edge later.
    task automatic issue(input logic [7:0] op, input logic [ADDR_W-1:0] addr,
                         input logic [7:0] data, input logic aligned,
                         input string req, input bit exp_acc);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr;
        cmd_data = data; cmd_aligned = aligned;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_aligned = 1'b1;
        check(req, "verdict {acc,rej}", {acc, rej}, exp_acc ? 2 : 1);
    endtask

    task automatic finish_write();
        @(negedge clk); done = 1'b1;
        @(negedge clk); done = 1'b0;
    endtask

    task automatic set_status(input logic [7:0] data);
        issue(WREN, '0, 8'h00, 1'b1, "R3", 1'b1);
        issue(WRSR, '0, data, 1'b1, "R8", 1'b1);
        finish_write();
    endtask

    task automatic t_reset();
        check("R1", "status after reset", status, 8'h00);
        check("R1", "busy after reset", busy, 0);
        check("R1", "deep_pd after reset", deep, 0);
        check("R1", "no verdict after reset", {acc, rej}, 0);
    endtask

    task automatic t_powerup();
        issue(WREN, '0, 8'h00, 1'b1, "R1", 1'b0);
        check("R1", "latch during wait", status[1], 0);
        issue(RDSR, '0, 8'h00, 1'b1, "R1", 1'b1);
        repeat (PUW + 5) @(negedge clk);
    endtask

    task automatic t_latch();
        issue(PP, 21'h000100, 8'h00, 1'b1, "R3", 1'b0);
        check("R3", "busy after rejected program", busy, 0);
        issue(WREN, '0, 8'h00, 1'b1, "R3", 1'b1);
        check("R11", "status with latch set", status, 8'h02);
        issue(WRDI, '0, 8'h00, 1'b1, "R4", 1'b1);
        check("R4", "latch after write-disable", status[1], 0);
    endtask

    task automatic t_unaligned();
        issue(WREN, '0, 8'h00, 1'b1, "R3", 1'b1);
        issue(PP, 21'h000000, 8'h00, 1'b0, "R2", 1'b0);
        check("R2", "latch after unaligned", status[1], 1);
        check("R2", "busy after unaligned", busy, 0);
        issue(DP, '0, 8'h00, 1'b0, "R2", 1'b0);
        check("R2", "deep_pd after unaligned", deep, 0);
        issue(WRDI, '0, 8'h00, 1'b1, "R4", 1'b1);
    endtask

    task automatic t_program();
        issue(WREN, '0, 8'h00, 1'b1, "R3", 1'b1);
        issue(PP, 21'h000000, 8'h00, 1'b1, "R9", 1'b1);
        check("R11", "status while busy", status, 8'h03);
        issue(SE, 21'h000000, 8'h00, 1'b1, "R9", 1'b0);
        issue(RDSR, '0, 8'h00, 1'b1, "R9", 1'b1);
        finish_write();
        check("R9", "busy after done", busy, 0);
        check("R4", "latch after program done", status[1], 0);
    endtask

    task automatic t_same_cycle();
        issue(WREN, '0, 8'h00, 1'b1, "R3", 1'b1);
        issue(SE, 21'h010000, 8'h00, 1'b1, "R12", 1'b1);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = WREN; cmd_aligned = 1'b1; done = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; done = 1'b0;
        check("R12", "verdict with done", {acc, rej}, 1);
        check("R12", "busy after done", busy, 0);
        check("R12", "latch after coincident cmd", status[1], 0);
    endtask

    task automatic t_protect();
        set_status(8'h04);                      // B = 1: top block 31
        check("R11", "status after load B=1", status, 8'h04);
        issue(WREN, '0, 8'h00, 1'b1, "R3", 1'b1);
        issue(PP, 21'h1F0000, 8'h00, 1'b1, "R6", 1'b0);
        check("R10", "latch after rejected program", status[1], 1);
        issue(PP, 21'h1EFFFF, 8'h00, 1'b1, "R6", 1'b1);
        finish_write();
        issue(WREN, '0, 8'h00, 1'b1, "R3", 1'b1);
        issue(CE, '0, 8'h00, 1'b1, "R7", 1'b0);
        set_status(8'h0C);                      // B = 3: blocks 28..31
        issue(WREN, '0, 8'h00, 1'b1, "R3", 1'b1);
        issue(SE, 21'h1C0000, 8'h00, 1'b1, "R6", 1'b0);
        issue(BE, 21'h1BFFFF, 8'h00, 1'b1, "R6", 1'b1);
        finish_write();
        set_status(8'h18);                      // B = 6: whole array
        issue(WREN, '0, 8'h00, 1'b1, "R3", 1'b1);
        issue(PP, 21'h000000, 8'h00, 1'b1, "R6", 1'b0);
        set_status(8'h3C);                      // B = 15: whole array
        issue(WREN, '0, 8'h00, 1'b1, "R3", 1'b1);
        issue(SE, 21'h000000, 8'h00, 1'b1, "R6", 1'b0);
        set_status(8'h00);
        issue(WREN, '0, 8'h00, 1'b1, "R3", 1'b1);
        issue(CE, '0, 8'h00, 1'b1, "R7", 1'b1);
        finish_write();
        check("R4", "latch after chip erase", status[1], 0);
    endtask

    task automatic t_hwlock();
        wp_n = 1'b0;
        set_status(8'h80);                      // write-disable bit clear: accepted
        check("R8", "status after setting bit 7", status, 8'h80);
        issue(WREN, '0, 8'h00, 1'b1, "R3", 1'b1);
        issue(WRSR, '0, 8'h00, 1'b1, "R8", 1'b0);
        check("R8", "status bit 7 kept", status[7], 1);
        check("R10", "latch after rejected status write", status[1], 1);
        wp_n = 1'b1;
        issue(WRSR, '0, 8'h00, 1'b1, "R8", 1'b1);
        finish_write();
        check("R8", "status after unlock write", status, 8'h00);
    endtask

    task automatic t_deep();
        issue(DP, '0, 8'h00, 1'b1, "R5", 1'b1);
        check("R5", "deep_pd raised", deep, 1);
        issue(WREN, '0, 8'h00, 1'b1, "R5", 1'b0);
        check("R5", "latch in deep_pd", status[1], 0);
        issue(RDSR, '0, 8'h00, 1'b1, "R5", 1'b0);
        issue(RES, '0, 8'h00, 1'b0, "R2", 1'b0);
        check("R2", "deep_pd after unaligned release", deep, 1);
        issue(RES, '0, 8'h00, 1'b1, "R5", 1'b1);
        check("R5", "deep_pd lowered", deep, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_powerup();
        t_latch();
        t_unaligned();
        t_program();
        t_same_cycle();
        t_protect();
        t_hwlock();
        t_deep();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule